// File: doc/BRIEF.md
# Data Access Translation and Fault Classifier

This block sits between a load/store unit and the translation lookaside buffer of a 32-bit core. For each data access it receives the virtual address, the access direction, the privilege level and three control bits: translation enable, single-virtual mode and store-queue user lock. It decodes which region of the address space the access falls in. From that it decides whether the access passes through untranslated, is masked down to a 29-bit external address, needs a table lookup, or faults at once.

When a lookup is needed, the block uses the TLB search result, which arrives as inputs: hit, multiple-hit, entry flags, physical page number and page mask. It then checks the entry's permissions and dirty state. The outcome is registered: one cycle after a request, a valid pulse carries either a physical address or a single classified fault code. On faults related to the TLB, the block also produces new values for the fault-address register and the page-table-entry-high register. The caller is expected to write those values into its own copies.

Top module: `xlat_fault_chk`

## Requirements
- R1: In privileged mode, an address at or above 0xE0000000 completes with no fault and with the physical address equal to the virtual address.
- R2: In privileged mode, an address from 0x80000000 to 0xBFFFFFFF completes with the address ANDed with 0x1FFFFFFF. A privileged address from 0xC0000000 to 0xDFFFFFFF, and any address below 0x80000000 in either mode, goes to translation.
- R3: In user mode, an address with bit 31 set passes through unchanged only when it lies in 0xE0000000..0xE3FFFFFF and sq_lock is 0. Any other user address with bit 31 set gives code 1 for a read or code 2 for a write.
- R4: When xlat_en is 0, an address headed for translation completes with the address ANDed with 0x1FFFFFFF, and lkp_req stays 0.
- R5: For a translated access, tlb_multi=1 gives code 5 (multi-hit, reset class) whatever tlb_hit says. Otherwise tlb_hit=0 gives code 3 for a read or code 4 for a write.
- R6: A translated user-mode read of an entry whose user-access flag (bit 6) is 0 gives code 6. Privileged reads ignore that bit.
- R7: A translated privileged write needs the writable flag (bit 5). A translated user write needs bits 5 and 6 both set. A write that fails its rule gives code 7.
- R8: A translated write that passes R7 but whose dirty flag (bit 2) is 0 gives code 8. When R7 and R8 both apply, only code 7 is reported.
- R9: A translated access with no fault completes with (tlb_ppn AND tlb_mask) OR (address AND NOT tlb_mask). Every faulting access reports res_paddr = 0.
- R10: With codes 3 through 8, tea_we pulses together with res_valid. At the same time, tea_val takes the faulting address and pteh_val takes address bits 31:10 above pteh_cur bits 9:0. With any other result, tea_we stays 0 and tea_val and pteh_val keep their values.
- R11: A request sampled at a clock edge produces a result one edge later. res_valid is high for exactly one cycle per request, and there is no result without a request.
- R12: lkp_req is high, combinationally, exactly when req_valid is high and the access goes to translation with xlat_en set. lkp_no_asid equals priv AND sv_mode.
- R13: The fault code is 4 bits wide, with 0 meaning no fault. Exactly one code is reported per access, and region faults (codes 1, 2) take precedence over every TLB check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 32 | Virtual data address |
| req_write | input | 1 | 1 = write, 0 = read |
| priv | input | 1 | 1 = privileged mode |
| xlat_en | input | 1 | Address translation enable |
| sv_mode | input | 1 | Single-virtual mode |
| sq_lock | input | 1 | 1 = store-queue window closed to user mode |
| tlb_hit | input | 1 | Lookup found one entry |
| tlb_multi | input | 1 | Lookup found more than one entry |
| tlb_flags | input | 9 | Flags of the matched entry |
| tlb_ppn | input | 32 | Physical page number of the matched entry |
| tlb_mask | input | 32 | Page mask of the matched entry |
| pteh_cur | input | 32 | Current page-table-entry-high value |
| lkp_req | output | 1 | Lookup result is consumed this cycle |
| lkp_no_asid | output | 1 | Lookup should ignore the address-space id |
| res_valid | output | 1 | Result pulse |
| res_code | output | 4 | Fault code, 0 = none |
| res_paddr | output | 32 | Physical address |
| tea_we | output | 1 | Fault-address register update strobe |
| tea_val | output | 32 | New fault-address value |
| pteh_val | output | 32 | New page-table-entry-high value |

## Verification
Two checks can fire on the same access. A write can fail its permission rule while its entry's dirty flag is also clear. A lookup can also report multi-hit and no hit together. The bench provokes both cases directly: it writes with flag patterns such as user-mode writable-but-not-user-accessible with dirty clear, and it raises tlb_multi with tlb_hit low. Across the random phase the flags are drawn freely, so overlaps keep happening. A reference function in the bench resolves each overlap by the stated priority. An access passes only when the single reported code is the higher-priority one, and when the fault-address outputs match that code.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int AW      = 32;
  localparam int FLAG_W  = 9;
  localparam int CODE_W  = 4;
  localparam int PAGE_LO = 10;

  localparam int FB_DIRTY = 2;
  localparam int FB_WRITE = 5;
  localparam int FB_USER  = 6;

  localparam logic [AW-1:0] EXT_MASK = 32'h1FFF_FFFF;
  localparam int            SQ_PFX_W = 6;
  localparam logic [SQ_PFX_W-1:0] SQ_PFX = 6'b111000;

  typedef enum logic [1:0] {
    RG_RAW  = 2'd0,
    RG_MASK = 2'd1,
    RG_XLAT = 2'd2,
    RG_AERR = 2'd3
  } region_e;

  typedef enum logic [CODE_W-1:0] {
    FC_NONE    = 4'd0,
    FC_AERR_RD = 4'd1,
    FC_AERR_WR = 4'd2,
    FC_MISS_RD = 4'd3,
    FC_MISS_WR = 4'd4,
    FC_MULTI   = 4'd5,
    FC_PROT_RD = 4'd6,
    FC_PROT_WR = 4'd7,
    FC_INIT_WR = 4'd8
  } fault_e;
endpackage

// File: rtl/xfc_region.sv
module xfc_region
  import xfc_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          priv,
  input  logic          sq_lock,
  input  logic          xlat_en,
  output region_e       kind
);
  region_e raw_kind;

  always_comb begin
    if (addr[AW-1]) begin
      if (priv) begin
        if (addr[AW-1:AW-3] == 3'b111)      raw_kind = RG_RAW;
        else if (addr[AW-2] == 1'b0)        raw_kind = RG_MASK;
        else                                raw_kind = RG_XLAT;
      end else begin
        if (addr[AW-1:AW-SQ_PFX_W] == SQ_PFX && !sq_lock) raw_kind = RG_RAW;
        else                                              raw_kind = RG_AERR;
      end
    end else begin
      raw_kind = RG_XLAT;
    end
  end

  always_comb begin
    kind = raw_kind;
    if (raw_kind == RG_XLAT && !xlat_en) kind = RG_MASK;
  end
endmodule

// File: rtl/xfc_classify.sv
module xfc_classify
  import xfc_pkg::*;
(
  input  region_e           kind,
  input  logic              is_write,
  input  logic              priv,
  input  logic              hit,
  input  logic              multi,
  input  logic [FLAG_W-1:0] flags,
  output fault_e            code
);
  logic f_user, f_wr, f_dirty, wr_denied, rd_denied;
  logic unused_flags;

  assign f_user  = flags[FB_USER];
  assign f_wr    = flags[FB_WRITE];
  assign f_dirty = flags[FB_DIRTY];
  assign unused_flags = ^{flags[FLAG_W-1:FB_USER+1], flags[FB_WRITE-1:FB_DIRTY+1],
                          flags[FB_DIRTY-1:0]};

  assign wr_denied = priv ? !f_wr : !(f_wr && f_user);
  assign rd_denied = !priv && !f_user;

  always_comb begin
    code = FC_NONE;
    unique case (kind)
      RG_AERR: code = is_write ? FC_AERR_WR : FC_AERR_RD;
      RG_XLAT: begin
        if (multi)             code = FC_MULTI;
        else if (!hit)         code = is_write ? FC_MISS_WR : FC_MISS_RD;
        else if (is_write) begin
          if (wr_denied)       code = FC_PROT_WR;
          else if (!f_dirty)   code = FC_INIT_WR;
        end else if (rd_denied) code = FC_PROT_RD;
      end
      default: code = FC_NONE;
    endcase
  end
endmodule

// File: rtl/xfc_compose.sv
module xfc_compose
  import xfc_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ppn,
  input  logic [AW-1:0] mask,
  input  region_e       kind,
  input  fault_e        code,
  output logic [AW-1:0] paddr,
  output logic          tlb_fault
);
  logic [AW-1:0] base;

  always_comb begin
    unique case (kind)
      RG_RAW:  base = addr;
      RG_MASK: base = addr & EXT_MASK;
      RG_XLAT: base = (ppn & mask) | (addr & ~mask);
      default: base = '0;
    endcase
    paddr = (code == FC_NONE) ? base : '0;
  end

  always_comb begin
    unique case (code)
      FC_MISS_RD, FC_MISS_WR, FC_MULTI,
      FC_PROT_RD, FC_PROT_WR, FC_INIT_WR: tlb_fault = 1'b1;
      default:                            tlb_fault = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlat_fault_chk.sv
module xlat_fault_chk
  import xfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic              priv,
  input  logic              xlat_en,
  input  logic              sv_mode,
  input  logic              sq_lock,
  input  logic              tlb_hit,
  input  logic              tlb_multi,
  input  logic [FLAG_W-1:0] tlb_flags,
  input  logic [AW-1:0]     tlb_ppn,
  input  logic [AW-1:0]     tlb_mask,
  input  logic [AW-1:0]     pteh_cur,
  output logic              lkp_req,
  output logic              lkp_no_asid,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code,
  output logic [AW-1:0]     res_paddr,
  output logic              tea_we,
  output logic [AW-1:0]     tea_val,
  output logic [AW-1:0]     pteh_val
);
  region_e       kind;
  fault_e        code;
  logic [AW-1:0] paddr;
  logic          tlb_fault;
  logic          unused_pteh;

  xfc_region u_region (
    .addr(req_addr), .priv(priv), .sq_lock(sq_lock), .xlat_en(xlat_en), .kind(kind)
  );

  xfc_classify u_class (
    .kind(kind), .is_write(req_write), .priv(priv), .hit(tlb_hit),
    .multi(tlb_multi), .flags(tlb_flags), .code(code)
  );

  xfc_compose u_comp (
    .addr(req_addr), .ppn(tlb_ppn), .mask(tlb_mask), .kind(kind), .code(code),
    .paddr(paddr), .tlb_fault(tlb_fault)
  );

  assign lkp_req     = req_valid && (kind == RG_XLAT);
  assign lkp_no_asid = priv && sv_mode;
  assign unused_pteh = ^pteh_cur[AW-1:PAGE_LO];

  // next-state
  logic              valid_d, tea_we_d, res_en, tea_en;
  logic [CODE_W-1:0] code_d;
  logic [AW-1:0]     paddr_d, tea_d, pteh_d;

  always_comb begin
    valid_d  = req_valid;
    tea_we_d = req_valid && tlb_fault;
    res_en   = req_valid;
    tea_en   = req_valid && tlb_fault;
    code_d   = code;
    paddr_d  = paddr;
    tea_d    = req_addr;
    pteh_d   = {req_addr[AW-1:PAGE_LO], pteh_cur[PAGE_LO-1:0]};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      tea_we    <= 1'b0;
    end else begin
      res_valid <= valid_d;
      tea_we    <= tea_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_code  <= '0;
      res_paddr <= '0;
    end else if (res_en) begin
      res_code  <= code_d;
      res_paddr <= paddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tea_val  <= '0;
      pteh_val <= '0;
    end else if (tea_en) begin
      tea_val  <= tea_d;
      pteh_val <= pteh_d;
    end
  end
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker
  import xfc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              xlat_en,
  input logic [AW-1:0]     pteh_cur,
  input logic [AW-1:0]     req_addr,
  input logic              lkp_req,
  input logic              res_valid,
  input logic [CODE_W-1:0] res_code,
  input logic [AW-1:0]     res_paddr,
  input logic              tea_we,
  input logic [AW-1:0]     tea_val,
  input logic [AW-1:0]     pteh_val
);
  a_r11_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid));

  a_r10_tea_with_tlb_code: assert property (@(posedge clk) disable iff (!rst_n)
    tea_we |-> (res_valid && res_code >= 4'd3 && res_code <= 4'd8));

  a_r10_tea_captures: assert property (@(posedge clk) disable iff (!rst_n)
    tea_we |-> (tea_val == $past(req_addr) &&
                pteh_val[PAGE_LO-1:0] == $past(pteh_cur[PAGE_LO-1:0]) &&
                pteh_val[AW-1:PAGE_LO] == tea_val[AW-1:PAGE_LO]));

  a_r13_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_code <= 4'd8);

  a_r9_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code != 4'd0) |-> res_paddr == '0);

  a_r4_no_lookup_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |-> (xlat_en && req_valid));
endmodule

bind xlat_fault_chk xfc_checker u_chk (.*);

// File: tb/sim_xlat_fault_chk.sv
`timescale 1ns/1ps
module sim_xlat_fault_chk;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, priv, xlat_en, sv_mode, sq_lock, tlb_hit, tlb_multi;
  logic [31:0] req_addr, tlb_ppn, tlb_mask, pteh_cur;
  logic [8:0]  tlb_flags;
  logic lkp_req, lkp_no_asid, res_valid, tea_we;
  logic [3:0]  res_code;
  logic [31:0] res_paddr, tea_val, pteh_val;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] last_tea, last_pteh;

  always #4 clk = ~clk;

  xlat_fault_chk u0 (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input logic [31:0] a, input logic wr, pv, at, sq, hit, mul,
                       input logic [8:0] fl, input logic [31:0] ppn, msk,
                       output logic [3:0] c, output logic [31:0] pa, output bit tlbf,
                       output bit look);
    bit xl;
    c = 0; pa = 0; tlbf = 0; xl = 0; look = 0;
    if (pv && a >= 32'hE000_0000) pa = a;
    else if (pv && a >= 32'h8000_0000 && a < 32'hC000_0000) pa = a & 32'h1FFF_FFFF;
    else if (!pv && a[31]) begin
      if (a <= 32'hE3FF_FFFF && a >= 32'hE000_0000 && !sq) pa = a;
      else c = wr ? 4'd2 : 4'd1;
    end else xl = 1;
    if (xl && !at) begin pa = a & 32'h1FFF_FFFF; xl = 0; end
    if (xl) begin
      look = 1;
      if (mul) c = 5;
      else if (!hit) c = wr ? 4'd4 : 4'd3;
      else if (wr && (pv ? !fl[5] : !(fl[5] && fl[6]))) c = 7;
      else if (wr && !fl[2]) c = 8;
      else if (!wr && !pv && !fl[6]) c = 6;
      if (c == 0) pa = (ppn & msk) | (a & ~msk);
      tlbf = (c != 0);
    end
    if (c != 0) pa = 0;
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic wr, pv, at, sv,
                        input logic sq, hit, mul, input logic [8:0] fl,
                        input logic [31:0] ppn, msk, pte);
    logic [3:0] ec; logic [31:0] ep; bit et, el;
    @(negedge clk);
    chk(res_valid == 1'b0, "R11", "idle res_valid", {31'd0, res_valid}, 32'd0);
    req_valid = 1; req_addr = a; req_write = wr; priv = pv; xlat_en = at; sv_mode = sv;
    sq_lock = sq; tlb_hit = hit; tlb_multi = mul; tlb_flags = fl; tlb_ppn = ppn;
    tlb_mask = msk; pteh_cur = pte;
    model(a, wr, pv, at, sq, hit, mul, fl, ppn, msk, ec, ep, et, el);
    #1;
    chk(lkp_req == el, "R12", "lkp_req", {31'd0, lkp_req}, {31'd0, el});
    chk(lkp_no_asid == (pv & sv), "R12", "lkp_no_asid", {31'd0, lkp_no_asid}, {31'd0, pv & sv});
    @(negedge clk);
    chk(res_valid == 1'b1, "R11", "res_valid", {31'd0, res_valid}, 32'd1);
    chk(res_code == ec, tag, "res_code", {28'd0, res_code}, {28'd0, ec});
    chk(res_paddr == ep, "R9", "res_paddr", res_paddr, ep);
    chk(tea_we == et, "R10", "tea_we", {31'd0, tea_we}, {31'd0, et});
    if (et) begin
      chk(tea_val == a, "R10", "tea_val", tea_val, a);
      chk(pteh_val == {a[31:10], pte[9:0]}, "R10", "pteh_val", pteh_val, {a[31:10], pte[9:0]});
      last_tea = a; last_pteh = {a[31:10], pte[9:0]};
    end else begin
      chk(tea_val == last_tea, "R10", "tea_val held", tea_val, last_tea);
      chk(pteh_val == last_pteh, "R10", "pteh_val held", pteh_val, last_pteh);
    end
    req_valid = 0;
  endtask

  localparam logic [31:0] M1K = 32'hFFFF_FC00, M4K = 32'hFFFF_F000,
                          M64K = 32'hFFFF_0000, M1M = 32'hFFF0_0000;

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] masks [4];
    masks[0] = M1K; masks[1] = M4K; masks[2] = M64K; masks[3] = M1M;
    void'($urandom(32'd4242));
    rst_n = 0; req_valid = 0; req_addr = 0; req_write = 0; priv = 0; xlat_en = 0;
    sv_mode = 0; sq_lock = 0; tlb_hit = 0; tlb_multi = 0; tlb_flags = 0; tlb_ppn = 0;
    tlb_mask = 0; pteh_cur = 0; last_tea = 0; last_pteh = 0;
    repeat (3) @(negedge clk);
    chk(res_valid == 0 && tea_we == 0, "R11", "reset valid", {30'd0, res_valid, tea_we}, 0);
    chk(res_code == 0 && res_paddr == 0, "R13", "reset code", res_paddr, 0);
    rst_n = 1;

    access("R1", 32'hE000_0000, 0, 1, 1, 0, 0, 0, 0, 9'h000, 0, M1K, 0);
    access("R1", 32'hFFFF_FFFC, 1, 1, 1, 1, 1, 0, 0, 9'h000, 0, M1K, 0);
    access("R2", 32'h8ABC_DEF0, 0, 1, 1, 0, 0, 0, 0, 9'h000, 0, M1K, 0);
    access("R2", 32'hBFFF_FFFF, 1, 1, 1, 0, 0, 0, 0, 9'h000, 0, M1K, 0);
    access("R2", 32'hC000_0400, 0, 1, 1, 1, 0, 1, 0, 9'h160, 32'h0555_5400, M1K, 32'h3FF);
    access("R3", 32'hE3FF_FFFC, 1, 0, 1, 0, 0, 0, 0, 9'h000, 0, M1K, 0);
    access("R3", 32'hE400_0000, 0, 0, 1, 0, 0, 0, 0, 9'h000, 0, M1K, 0);
    access("R3", 32'hE000_0000, 1, 0, 1, 0, 1, 0, 0, 9'h000, 0, M1K, 0);
    access("R3", 32'h8000_0000, 1, 0, 0, 0, 0, 1, 0, 9'h1FF, 0, M1K, 0);
    access("R4", 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, 9'h000, 0, M1K, 0);
    access("R4", 32'hC765_4321, 1, 1, 0, 1, 0, 0, 0, 9'h000, 0, M1K, 0);
    access("R5", 32'h0000_1000, 0, 0, 1, 0, 0, 0, 0, 9'h1FF, 0, M4K, 32'h2AB);
    access("R5", 32'h0000_2000, 1, 1, 1, 0, 0, 0, 0, 9'h1FF, 0, M4K, 32'h155);
    access("R5", 32'h0000_3000, 0, 1, 1, 0, 0, 0, 1, 9'h1FF, 0, M4K, 32'h0AA);
    access("R5", 32'h0000_3400, 1, 0, 1, 0, 0, 1, 1, 9'h1FF, 0, M4K, 32'h0AA);
    access("R6", 32'h0040_0010, 0, 0, 1, 0, 0, 1, 0, 9'h124, 32'h0100_0000, M1K, 0);
    access("R6", 32'h0040_0010, 0, 1, 1, 0, 0, 1, 0, 9'h124, 32'h0100_0000, M1K, 0);
    access("R7", 32'h0050_0000, 1, 1, 1, 0, 0, 1, 0, 9'h144, 0, M1K, 0);
    access("R7", 32'h0050_0000, 1, 0, 1, 0, 0, 1, 0, 9'h124, 0, M1K, 0);
    access("R7", 32'h0050_0004, 1, 1, 1, 0, 0, 1, 0, 9'h124, 32'h0222_2000, M1K, 0);
    access("R8", 32'h0060_0000, 1, 0, 1, 0, 0, 1, 0, 9'h120, 0, M1K, 0);
    access("R8", 32'h0060_0000, 1, 0, 1, 0, 0, 1, 0, 9'h100, 0, M1K, 0);
    access("R8", 32'h0060_0000, 0, 0, 1, 0, 0, 1, 0, 9'h140, 32'h0444_0000, M64K, 0);
    access("R9", 32'h7ABC_DEF8, 1, 1, 1, 0, 0, 1, 0, 9'h1E4, 32'h1234_5678, M1M, 0);
    access("R13", 32'hE800_0000, 1, 0, 1, 0, 0, 0, 1, 9'h000, 0, M1K, 0);

    for (int i = 0; i < 500; i++) begin
      logic [31:0] a; logic [2:0] sel;
      sel = 3'($urandom % 6);
      a = $urandom;
      case (sel)
        3'd0: a[31] = 1'b0;
        3'd1: a[31:29] = 3'b111;
        3'd2: a[31:26] = 6'b111000;
        3'd3: a[31:29] = 3'b110;
        default: ;
      endcase
      access("R13", a, 1'($urandom), 1'($urandom), ($urandom % 5) != 0, 1'($urandom),
             ($urandom % 3) == 0, ($urandom % 5) != 0, ($urandom % 8) == 0,
             9'($urandom), $urandom, masks[$urandom % 4], $urandom);
    end
    @(negedge clk);
    chk(res_valid == 0, "R11", "final idle", {31'd0, res_valid}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule